// File: doc/BRIEF.md
# Deferred Exception Token Tracker

This block is the register side of a small in-order execution stage that handles exceptions by deferring them. Each general register carries one extra token bit that marks its data as unusable. A speculative load whose access faults sets that token instead of trapping. Speculative compute operations carry the token from their sources into their destination. A later check operation tests the token and redirects the program to recovery code. Non-speculative operations, such as a plain load or a store-like update of outside state, report faults at once, and they refuse to consume a tokened source.

One decoded operation is accepted per cycle. The operation's results appear on registered outputs in the next cycle: the register write (index, data, token), the fault strobes, the branch resolution of a check, and the store request. The register file is written from that output stage. Its read ports forward the pending write first, so an operation issued directly after its producer sees the new value and token.

Top module: `dxt_tracker`

## Requirements
- R1: While reset is held, every output strobe (`wr_en_o`, `ld_fault_o`, `use_fault_o`, `br_valid_o`, `st_valid_o`) is low. After reset, every register's token reads clear.
- R2: A non-speculative load (`op_kind_i` = 1) with `ld_fault_i` low writes `ld_data_i` to the destination with its token clear. With `ld_fault_i` high it pulses `ld_fault_o` and writes nothing.
- R3: A speculative load (`op_kind_i` = 2) never raises `ld_fault_o`. With `ld_fault_i` high it writes the destination with token set and data zero. Otherwise it writes `ld_data_i` with token clear.
- R4: A compute operation (`op_kind_i` = 3) writes src_a + src_b to the destination, with a token equal to the OR of the source tokens. When that token is set, the data is zero. A compute operation never creates a token from clean sources.
- R5: A check operation (`op_kind_i` = 5) tests the token of src_a and pulses `br_valid_o`. If the token is clear, `br_taken_o` is 0 and the target is `pc_i` + STEP (16). If the token is set, `br_taken_o` is 1 and the target is `pc_i` plus the sign-extended `imm_i`.
- R6: A store-like operation (`op_kind_i` = 4) with both source tokens clear pulses `st_valid_o`, with `st_addr_o` = src_a data and `st_data_o` = src_b data. If either source token is set, it pulses `use_fault_o` and issues no store.
- R7: Any write of a valid result clears a token that was set before on that register.
- R8: Register 0 reads as zero with its token clear. Writes to register 0 are dropped, and `wr_en_o` stays low for them.
- R9: An operation issued in the cycle right after its producer reads the producer's data and token.
- R10: Results appear one cycle after the operation is sampled, with at most one strobe per cycle. Inputs sampled with `op_valid_i` low change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid_i | input | 1 | An operation is present this cycle |
| op_kind_i | input | 3 | 0 none, 1 load, 2 speculative load, 3 compute, 4 store-like, 5 check |
| dst_i | input | 5 | Destination register index |
| src_a_i | input | 5 | First source index (check operand, store address) |
| src_b_i | input | 5 | Second source index (store data) |
| imm_i | input | 13 | Signed offset of a check operation |
| pc_i | input | 32 | Address of the current operation |
| ld_data_i | input | 64 | Data returned for a load |
| ld_fault_i | input | 1 | The load's access faults |
| wr_en_o | output | 1 | Register write in this cycle |
| wr_idx_o | output | 5 | Written register |
| wr_data_o | output | 64 | Written data |
| wr_tok_o | output | 1 | Written token |
| ld_fault_o | output | 1 | Immediate fault of a non-speculative load |
| use_fault_o | output | 1 | Non-speculative operation read a tokened source |
| br_valid_o | output | 1 | A check operation resolved |
| br_taken_o | output | 1 | The check found a token and branches |
| br_target_o | output | 32 | Next address chosen by the check |
| st_valid_o | output | 1 | Store request |
| st_addr_o | output | 64 | Store address (src_a data) |
| st_data_o | output | 64 | Store data (src_b data) |

## Verification
The most delicate overlap is a register-file write landing in the same cycle that the next operation reads the same register. The write-first forwarding must then hand the fresh token to a check, store or compute operation. The bench provokes this by issuing a faulting speculative load and, on the very next cycle, a check, a dependent compute, or a store on that register. It judges the result at the outputs: the branch must be taken, the compute result must carry the token with zero data, and the store must turn into a use fault. Clearing by a valid write is tested the same way: a load over a tokened register is followed at once by a check on it, which must not be taken.

// File: rtl/dxt_pkg.sv
package dxt_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_LD  = 3'd1,
    OP_LDS = 3'd2,
    OP_ALU = 3'd3,
    OP_ST  = 3'd4,
    OP_CHK = 3'd5
  } op_e;
endpackage

// File: rtl/dxt_rst_sync.sv
module dxt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  localparam int MSB = STAGES - 1;
  logic [MSB:0] sync_q;
  logic [MSB:0] sync_d;

  always_comb begin
    sync_d = {sync_q[MSB:0], 1'b1} >> 0;
    sync_d = (STAGES > 1) ? {sync_q[MSB-1:0], 1'b1} : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[MSB];
endmodule

// File: rtl/dxt_regfile.sv
module dxt_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 64,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          wtok,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [DW-1:0] a_data,
  output logic          a_tok,
  output logic [DW-1:0] b_data,
  output logic          b_tok
);
  localparam int NPORT = 2;

  logic [DW-1:0]   mem [NREG];
  logic [NREG-1:0] tok_q;
  logic [NREG-1:0] tok_d;
  logic            wr_ok;
  logic [AW-1:0]   ridx [NPORT];

  assign wr_ok   = we && (widx != '0);
  assign ridx[0] = ra;
  assign ridx[1] = rb;

  always_comb begin
    tok_d = tok_q;
    if (wr_ok) tok_d[widx] = wtok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= '0;
    else        tok_q <= tok_d;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[widx] <= wdata;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic [DW-1:0] d;
    logic          t;
    always_comb begin
      if (ridx[p] == '0) begin
        d = '0;
        t = 1'b0;
      end else if (wr_ok && (widx == ridx[p])) begin
        d = wdata;
        t = wtok;
      end else begin
        d = mem[ridx[p]];
        t = tok_q[ridx[p]];
      end
    end
  end

  assign a_data = g_rd[0].d;
  assign a_tok  = g_rd[0].t;
  assign b_data = g_rd[1].d;
  assign b_tok  = g_rd[1].t;
endmodule

// File: rtl/dxt_exec.sv
module dxt_exec
  import dxt_pkg::*;
#(
  parameter int DW   = 64,
  parameter int AW   = 5,
  parameter int PCW  = 32,
  parameter int IMW  = 13,
  parameter int STEP = 16
) (
  input  logic           op_valid,
  input  logic [2:0]     op_kind,
  input  logic [AW-1:0]  dst,
  input  logic [IMW-1:0] imm,
  input  logic [PCW-1:0] pc,
  input  logic [DW-1:0]  ld_data,
  input  logic           ld_fault,
  input  logic [DW-1:0]  a_data,
  input  logic           a_tok,
  input  logic [DW-1:0]  b_data,
  input  logic           b_tok,
  output logic           n_wen,
  output logic [AW-1:0]  n_widx,
  output logic [DW-1:0]  n_wdata,
  output logic           n_wtok,
  output logic           n_ldf,
  output logic           n_usef,
  output logic           n_brv,
  output logic           n_brt,
  output logic [PCW-1:0] n_btgt,
  output logic           n_stv,
  output logic [DW-1:0]  n_sta,
  output logic [DW-1:0]  n_std
);
  localparam int EXT = PCW - IMW;

  op_e            kind;
  logic           dst_live;
  logic           any_tok;
  logic [DW-1:0]  sum;
  logic [PCW-1:0] off_ext;
  logic [PCW-1:0] pc_seq;
  logic [PCW-1:0] pc_jmp;

  assign kind     = op_e'(op_kind);
  assign dst_live = (dst != '0);
  assign any_tok  = a_tok | b_tok;
  assign sum      = a_data + b_data;
  assign off_ext  = {{EXT{imm[IMW-1]}}, imm};
  assign pc_seq   = pc + PCW'(STEP);
  assign pc_jmp   = pc + off_ext;

  always_comb begin
    n_wen   = 1'b0;
    n_widx  = dst;
    n_wdata = '0;
    n_wtok  = 1'b0;
    n_ldf   = 1'b0;
    n_usef  = 1'b0;
    n_brv   = 1'b0;
    n_brt   = 1'b0;
    n_btgt  = pc_seq;
    n_stv   = 1'b0;
    n_sta   = a_data;
    n_std   = b_data;
    if (op_valid) begin
      case (kind)
        OP_LD: begin
          if (ld_fault) begin
            n_ldf = 1'b1;
          end else begin
            n_wen   = dst_live;
            n_wdata = ld_data;
          end
        end
        OP_LDS: begin
          n_wen   = dst_live;
          n_wtok  = ld_fault;
          n_wdata = ld_fault ? '0 : ld_data;
        end
        OP_ALU: begin
          n_wen   = dst_live;
          n_wtok  = any_tok;
          n_wdata = any_tok ? '0 : sum;
        end
        OP_ST: begin
          if (any_tok) n_usef = 1'b1;
          else         n_stv  = 1'b1;
        end
        OP_CHK: begin
          n_brv  = 1'b1;
          n_brt  = a_tok;
          n_btgt = a_tok ? pc_jmp : pc_seq;
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/dxt_tracker.sv
module dxt_tracker
  import dxt_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 64,
  parameter int PCW  = 32,
  parameter int IMW  = 13,
  parameter int STEP = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid_i,
  input  logic [2:0]     op_kind_i,
  input  logic [AW-1:0]  dst_i,
  input  logic [AW-1:0]  src_a_i,
  input  logic [AW-1:0]  src_b_i,
  input  logic [IMW-1:0] imm_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [DW-1:0]  ld_data_i,
  input  logic           ld_fault_i,
  output logic           wr_en_o,
  output logic [AW-1:0]  wr_idx_o,
  output logic [DW-1:0]  wr_data_o,
  output logic           wr_tok_o,
  output logic           ld_fault_o,
  output logic           use_fault_o,
  output logic           br_valid_o,
  output logic           br_taken_o,
  output logic [PCW-1:0] br_target_o,
  output logic           st_valid_o,
  output logic [DW-1:0]  st_addr_o,
  output logic [DW-1:0]  st_data_o
);
  logic           rst_s;
  logic [DW-1:0]  a_data, b_data;
  logic           a_tok, b_tok;

  logic           n_wen, n_wtok, n_ldf, n_usef, n_brv, n_brt, n_stv;
  logic [AW-1:0]  n_widx;
  logic [DW-1:0]  n_wdata, n_sta, n_std;
  logic [PCW-1:0] n_btgt;

  logic           wen_q, wtok_q, ldf_q, usef_q, brv_q, brt_q, stv_q;
  logic [AW-1:0]  widx_q;
  logic [DW-1:0]  wdata_q, sta_q, std_q;
  logic [PCW-1:0] btgt_q;

  dxt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  dxt_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk    (clk),
    .rst_n  (rst_s),
    .we     (wen_q),
    .widx   (widx_q),
    .wdata  (wdata_q),
    .wtok   (wtok_q),
    .ra     (src_a_i),
    .rb     (src_b_i),
    .a_data (a_data),
    .a_tok  (a_tok),
    .b_data (b_data),
    .b_tok  (b_tok)
  );

  dxt_exec #(.DW(DW), .AW(AW), .PCW(PCW), .IMW(IMW), .STEP(STEP)) u_ex (
    .op_valid (op_valid_i),
    .op_kind  (op_kind_i),
    .dst      (dst_i),
    .imm      (imm_i),
    .pc       (pc_i),
    .ld_data  (ld_data_i),
    .ld_fault (ld_fault_i),
    .a_data   (a_data),
    .a_tok    (a_tok),
    .b_data   (b_data),
    .b_tok    (b_tok),
    .n_wen    (n_wen),
    .n_widx   (n_widx),
    .n_wdata  (n_wdata),
    .n_wtok   (n_wtok),
    .n_ldf    (n_ldf),
    .n_usef   (n_usef),
    .n_brv    (n_brv),
    .n_brt    (n_brt),
    .n_btgt   (n_btgt),
    .n_stv    (n_stv),
    .n_sta    (n_sta),
    .n_std    (n_std)
  );

  // control stage: reset
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wen_q  <= 1'b0;
      wtok_q <= 1'b0;
      ldf_q  <= 1'b0;
      usef_q <= 1'b0;
      brv_q  <= 1'b0;
      brt_q  <= 1'b0;
      stv_q  <= 1'b0;
    end else begin
      wen_q  <= n_wen;
      wtok_q <= n_wtok;
      ldf_q  <= n_ldf;
      usef_q <= n_usef;
      brv_q  <= n_brv;
      brt_q  <= n_brt;
      stv_q  <= n_stv;
    end
  end

  // data stage: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (n_wen) begin
      widx_q  <= n_widx;
      wdata_q <= n_wdata;
    end
    if (n_brv) btgt_q <= n_btgt;
    if (n_stv) begin
      sta_q <= n_sta;
      std_q <= n_std;
    end
  end

  assign wr_en_o     = wen_q;
  assign wr_idx_o    = widx_q;
  assign wr_data_o   = wdata_q;
  assign wr_tok_o    = wtok_q;
  assign ld_fault_o  = ldf_q;
  assign use_fault_o = usef_q;
  assign br_valid_o  = brv_q;
  assign br_taken_o  = brt_q;
  assign br_target_o = btgt_q;
  assign st_valid_o  = stv_q;
  assign st_addr_o   = sta_q;
  assign st_data_o   = std_q;
endmodule

// File: rtl/dxt_tracker_chk.sv
module dxt_tracker_chk #(
  parameter int AW   = 5,
  parameter int PCW  = 32,
  parameter int IMW  = 13,
  parameter int STEP = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid_i,
  input logic [2:0]     op_kind_i,
  input logic [AW-1:0]  dst_i,
  input logic [IMW-1:0] imm_i,
  input logic [PCW-1:0] pc_i,
  input logic           ld_fault_i,
  input logic           wr_en_o,
  input logic [AW-1:0]  wr_idx_o,
  input logic [63:0]    wr_data_o,
  input logic           wr_tok_o,
  input logic           ld_fault_o,
  input logic           use_fault_o,
  input logic           br_valid_o,
  input logic           br_taken_o,
  input logic [PCW-1:0] br_target_o,
  input logic           st_valid_o
);
  localparam int EXT = PCW - IMW;

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en_o, ld_fault_o, use_fault_o, br_valid_o, st_valid_o})); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> !(wr_en_o || ld_fault_o || use_fault_o || br_valid_o || st_valid_o)); // R10

  AST_LD_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_kind_i == 3'd1 && ld_fault_i) |=> (ld_fault_o && !wr_en_o)); // R2

  AST_LDS_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_kind_i == 3'd2 && ld_fault_i && dst_i != '0)
      |=> (wr_en_o && wr_tok_o && !ld_fault_o)); // R3

  AST_TOKEN_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_tok_o) |-> (wr_data_o == '0)); // R4

  AST_CHK_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid_o && !br_taken_o) |-> (br_target_o == $past(pc_i) + PCW'(STEP))); // R5

  AST_CHK_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid_o && br_taken_o)
      |-> (br_target_o == $past(pc_i) + {{EXT{$past(imm_i[IMW-1])}}, $past(imm_i)})); // R5

  AST_R0_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_idx_o != '0)); // R8
endmodule

bind dxt_tracker dxt_tracker_chk #(.AW(AW), .PCW(PCW), .IMW(IMW), .STEP(STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid_i  (op_valid_i),
  .op_kind_i   (op_kind_i),
  .dst_i       (dst_i),
  .imm_i       (imm_i),
  .pc_i        (pc_i),
  .ld_fault_i  (ld_fault_i),
  .wr_en_o     (wr_en_o),
  .wr_idx_o    (wr_idx_o),
  .wr_data_o   (wr_data_o[63:0]),
  .wr_tok_o    (wr_tok_o),
  .ld_fault_o  (ld_fault_o),
  .use_fault_o (use_fault_o),
  .br_valid_o  (br_valid_o),
  .br_taken_o  (br_taken_o),
  .br_target_o (br_target_o),
  .st_valid_o  (st_valid_o)
);

// File: tb/dxt_tracker_test.sv
module dxt_tracker_test;
  logic        clk;
  logic        rst_n;
  logic        op_valid_i;
  logic [2:0]  op_kind_i;
  logic [4:0]  dst_i, src_a_i, src_b_i;
  logic [12:0] imm_i;
  logic [31:0] pc_i;
  logic [63:0] ld_data_i;
  logic        ld_fault_i;
  logic        wr_en_o;
  logic [4:0]  wr_idx_o;
  logic [63:0] wr_data_o;
  logic        wr_tok_o;
  logic        ld_fault_o, use_fault_o, br_valid_o, br_taken_o, st_valid_o;
  logic [31:0] br_target_o;
  logic [63:0] st_addr_o, st_data_o;

  dxt_tracker uut (.*);

  typedef struct packed {
    logic        wen;
    logic [4:0]  widx;
    logic [63:0] wdata;
    logic        wtok;
    logic        ldf;
    logic        usef;
    logic        brv;
    logic        brt;
    logic [31:0] btgt;
    logic        stv;
    logic [63:0] sta;
    logic [63:0] std;
  } res_t;

  res_t        exp_q[$];
  string       tag_q[$];
  logic [63:0] mdat [32];
  logic        mtok [32];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: compare each committed result against the queued prediction
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        res_t  e;
        res_t  a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a       = '0;
        a.wen   = wr_en_o;
        a.widx  = wr_en_o ? wr_idx_o : 5'd0;
        a.wdata = wr_en_o ? wr_data_o : 64'd0;
        a.wtok  = wr_en_o ? wr_tok_o : 1'b0;
        a.ldf   = ld_fault_o;
        a.usef  = use_fault_o;
        a.brv   = br_valid_o;
        a.brt   = br_valid_o ? br_taken_o : 1'b0;
        a.btgt  = br_valid_o ? br_target_o : 32'd0;
        a.stv   = st_valid_o;
        a.sta   = st_valid_o ? st_addr_o : 64'd0;
        a.std   = st_valid_o ? st_data_o : 64'd0;
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  // driver: apply one operation and predict its outcome from the model
  task automatic issue(input logic v, input logic [2:0] k, input logic [4:0] d,
                       input logic [4:0] a, input logic [4:0] b, input logic [63:0] ldv,
                       input logic lf, input int im, input int pcv, input string tag);
    res_t        e;
    logic [63:0] ad, bd;
    logic        at, bt;
    @(negedge clk);
    op_valid_i = v;  op_kind_i = k;  dst_i = d;  src_a_i = a;  src_b_i = b;
    ld_data_i = ldv; ld_fault_i = lf; imm_i = im[12:0]; pc_i = pcv;
    ad = (a == 0) ? 64'd0 : mdat[a];
    at = (a == 0) ? 1'b0  : mtok[a];
    bd = (b == 0) ? 64'd0 : mdat[b];
    bt = (b == 0) ? 1'b0  : mtok[b];
    e = '0;
    if (v) begin
      case (k)
        3'd1: begin
          if (lf) e.ldf = 1'b1;
          else if (d != 0) begin
            e.wen = 1'b1; e.widx = d; e.wdata = ldv; e.wtok = 1'b0;
          end
        end
        3'd2: if (d != 0) begin
          e.wen = 1'b1; e.widx = d; e.wtok = lf; e.wdata = lf ? 64'd0 : ldv;
        end
        3'd3: if (d != 0) begin
          e.wen = 1'b1; e.widx = d; e.wtok = at | bt;
          e.wdata = (at | bt) ? 64'd0 : ad + bd;
        end
        3'd4: begin
          if (at | bt) e.usef = 1'b1;
          else begin
            e.stv = 1'b1; e.sta = ad; e.std = bd;
          end
        end
        3'd5: begin
          e.brv = 1'b1; e.brt = at;
          e.btgt = at ? pcv + im : pcv + 16;
        end
        default: ;
      endcase
    end
    if (e.wen) begin
      mdat[d] = e.wdata;
      mtok[d] = e.wtok;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mdat[i] = 64'd0;
      mtok[i] = 1'b0;
    end
    rst_n = 1'b0; op_valid_i = 1'b0; op_kind_i = 3'd0; dst_i = '0; src_a_i = '0;
    src_b_i = '0; imm_i = '0; pc_i = '0; ld_data_i = '0; ld_fault_i = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if ({wr_en_o, ld_fault_o, use_fault_o, br_valid_o, st_valid_o} !== 5'b0) begin
      errors++;
      $display("FAIL R1: actual strobes %b expected 00000",
               {wr_en_o, ld_fault_o, use_fault_o, br_valid_o, st_valid_o});
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: tokens clear after reset
    issue(1, 3'd5, 5'd0, 5'd1,  5'd0, 64'd0, 0, 64,  32'h1000, "R1 chk r1 after reset");
    issue(1, 3'd5, 5'd0, 5'd31, 5'd0, 64'd0, 0, 64,  32'h1010, "R1 chk r31 after reset");
    // R2 plain loads
    issue(1, 3'd1, 5'd1, 5'd0, 5'd0, 64'h10, 0, 0, 32'h1020, "R2 load r1");
    issue(1, 3'd1, 5'd2, 5'd0, 5'd0, 64'h20, 0, 0, 32'h1030, "R2 load r2");
    issue(1, 3'd1, 5'd3, 5'd0, 5'd0, 64'h33, 1, 0, 32'h1040, "R2 faulting load traps");
    issue(1, 3'd1, 5'd0, 5'd0, 5'd0, 64'h5,  0, 0, 32'h1050, "R8 load to r0 dropped");
    // R9 bypass and R8 zero reads
    issue(1, 3'd1, 5'd11, 5'd0, 5'd0, 64'h100, 0, 0, 32'h1060, "R2 load r11");
    issue(1, 3'd3, 5'd4, 5'd11, 5'd2, 64'd0, 0, 0, 32'h1070, "R9 compute reads r11 just written");
    issue(1, 3'd3, 5'd5, 5'd0, 5'd1, 64'd0, 0, 0, 32'h1080, "R8 compute r0 reads zero");
    // R3 speculative fault, then R5 taken check back to back
    issue(1, 3'd2, 5'd6, 5'd0, 5'd0, 64'hdead, 1, 0, 32'h1090, "R3 speculative load defers");
    issue(1, 3'd5, 5'd0, 5'd6, 5'd0, 64'd0, 0, -8, 32'h10a0, "R5 R9 check taken back to back");
    // R4 propagation chain and no creation
    issue(1, 3'd3, 5'd7, 5'd6, 5'd1, 64'd0, 0, 0, 32'h10b0, "R4 compute propagates token");
    issue(1, 3'd3, 5'd8, 5'd2, 5'd7, 64'd0, 0, 0, 32'h10c0, "R4 chain propagates via src_b");
    issue(1, 3'd3, 5'd9, 5'd1, 5'd2, 64'd0, 0, 0, 32'h10d0, "R4 clean compute creates no token");
    issue(1, 3'd5, 5'd0, 5'd9, 5'd0, 64'd0, 0, 4000, 32'h10e0, "R4 check clean result not taken");
    // R6 stores
    issue(1, 3'd4, 5'd0, 5'd1, 5'd2, 64'd0, 0, 0, 32'h10f0, "R6 clean store fires");
    issue(1, 3'd4, 5'd0, 5'd1, 5'd8, 64'd0, 0, 0, 32'h1100, "R6 store data token faults");
    issue(1, 3'd4, 5'd0, 5'd6, 5'd2, 64'd0, 0, 0, 32'h1110, "R6 store address token faults");
    // R3 clean speculative load, R7 clearing
    issue(1, 3'd2, 5'd10, 5'd0, 5'd0, 64'habcd, 0, 0, 32'h1120, "R3 clean speculative load");
    issue(1, 3'd1, 5'd6, 5'd0, 5'd0, 64'h77, 0, 0, 32'h1130, "R7 load over tokened r6");
    issue(1, 3'd5, 5'd0, 5'd6, 5'd0, 64'd0, 0, 96, 32'h1140, "R7 check r6 now clear");
    issue(1, 3'd3, 5'd7, 5'd6, 5'd6, 64'd0, 0, 0, 32'h1150, "R7 compute clears r7");
    issue(1, 3'd4, 5'd0, 5'd7, 5'd10, 64'd0, 0, 0, 32'h1160, "R7 store sees cleared r7");
    // R10 invalid operation has no effect, R8 speculative write to r0
    issue(0, 3'd2, 5'd6, 5'd0, 5'd0, 64'd0, 1, 0, 32'h1170, "R10 idle cycle quiet");
    issue(1, 3'd5, 5'd0, 5'd6, 5'd0, 64'd0, 0, 96, 32'h1180, "R10 idle left r6 clear");
    issue(1, 3'd2, 5'd0, 5'd0, 5'd0, 64'd0, 1, 0, 32'h1190, "R8 speculative fault to r0 dropped");
    issue(1, 3'd5, 5'd0, 5'd0, 5'd0, 64'd0, 0, 96, 32'h11a0, "R8 check r0 never taken");
    // R5 extreme offsets
    issue(1, 3'd2, 5'd12, 5'd0, 5'd0, 64'd0, 1, 0, 32'h11b0, "R3 speculative fault r12");
    issue(1, 3'd5, 5'd0, 5'd12, 5'd0, 64'd0, 0, 4095, 32'h11c0, "R5 taken max positive offset");
    issue(1, 3'd5, 5'd0, 5'd12, 5'd0, 64'd0, 0, -4096, 32'h11d0, "R5 taken max negative offset");
    issue(0, 3'd0, 5'd0, 5'd0, 5'd0, 64'd0, 0, 0, 32'h0, "R10 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule